// File: doc/BRIEF.md
# Parallel Printer Port Host Registers

This block is the host-side register front end of a classic byte-wide printer port that can also turn its data lines around for input. A processor reaches it over a small 8-bit register bus with a 2-bit offset, a write strobe, a read strobe and separate write and read data. Three byte registers sit behind that bus. The data register latches the byte driven onto the eight data lines. The status register reports five printer-side input pins. The control register drives four open-collector handshake lines and holds two mode bits.

On the pin side, the data lines come out as a value plus an output enable, with a separate sampled input. Each control line is modelled as a pull-low request plus the level sensed on the wire. This lets an external device override a released line and lets software read the result. The acknowledge input is synchronized and watched by a small state machine. Every low-to-high transition produces a one-cycle interrupt pulse. The pulse reaches the interrupt output only while the interrupt driver is enabled. While the driver is disabled, its output enable is low so the line floats.

The edge watcher has three states. `ACK_WAIT_LOW` holds while the synchronized acknowledge is high or unknown, and moves to `ACK_ARMED` when it is seen low. `ACK_ARMED` waits for it to go high and then moves to `ACK_FIRE`. `ACK_FIRE` lasts one cycle and raises the pulse. From there it goes back to `ACK_ARMED` if the line has already dropped again, and otherwise to `ACK_WAIT_LOW`. Reset enters `ACK_WAIT_LOW`, so a line that is already high at reset does not fire.

Top module: `lpt_host_port`

## Requirements
- R1: After reset the data latch is 0x00 with the data drivers enabled, the control register reads 0xC4 with all four control lines released (no pull-low), and the interrupt output and its enable are both low.
- R2: A write to offset 0 places the byte on `pd_out` from the next cycle, and it holds until the next offset-0 write. A read of offset 0 returns the level present on `pd_in`, not the latch.
- R3: Control bit 5 set to 1 selects input mode and drops `pd_oe`. Offset-0 writes made in input mode still update the latch. The new value appears on the pins once bit 5 is cleared.
- R4: A read of offset 1 returns bit 7 = inverted busy pin, bit 6 = acknowledge pin, bit 5 = paper-out pin, bit 4 = selected pin, bit 3 = error pin, and bits 2..0 = 1.
- R5: Control bits 0 (strobe), 1 (autofeed) and 3 (select) are inverted to the pin, so writing 1 pulls that line low. Bit 2 (initialize) is true to the pin, so writing 0 pulls it low. `ctl_drive_low[i]` = 1 means line i is pulled low.
- R6: A read of offset 2 returns, in bits 3..0, the sensed line levels `ctl_pin_in` with the same per-bit inversions as R5. Bits 5 and 4 return the stored mode bits.
- R7: Control bits 7 and 6 ignore writes and always read as 1.
- R8: While control bit 4 is 1, `irq_oe` is high. Each rising edge of the acknowledge pin then gives exactly one single-cycle `irq_out` pulse, three clock edges after the pin change. While bit 4 is 0, `irq_oe` and `irq_out` are low and edges are lost.
- R9: A read of offset 3 returns 0xFF. Writes to offsets 1 and 3 change neither the data latch nor the control register.
- R10: `bus_rdata` updates one cycle after a cycle with `bus_rd` high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pd_out | output | 8 | Data latch driven to the data lines |
| pd_oe | output | 1 | Data line driver enable |
| pd_in | input | 8 | Sensed data line levels |
| st_busy_pin | input | 1 | Busy pin level |
| st_ack_pin | input | 1 | Acknowledge pin level |
| st_paper_pin | input | 1 | Paper-out pin level |
| st_sel_pin | input | 1 | Selected pin level |
| st_err_pin | input | 1 | Error pin level (low = error) |
| ctl_drive_low | output | 4 | Pull-low request per control line (0 strobe, 1 autofeed, 2 initialize, 3 select) |
| ctl_pin_in | input | 4 | Sensed control line levels |
| irq_out | output | 1 | Interrupt pulse |
| irq_oe | output | 1 | Interrupt line driver enable |

## Verification
The assertions check several properties on every cycle. They check the one-cycle latency of the data latch and its hold between writes (R2). They check that `pd_oe` follows the written input-mode bit (R3) and that each control write maps to the pull-low pattern (R5). They also check the 0xFF result for offset 3 (R9), the hold of `bus_rdata` outside reads (R10), and that every interrupt pulse is one cycle wide and only appears with its driver enabled (R8). Other behaviours can only be shown by the bench's scenarios. These are the per-bit status polarities (R4) and control readback when an outside device pulls a released line low (R6). They also include the survival of a data write made in input mode, exactly one pulse per acknowledge rise with none for a line held high, and edges lost while the driver is disabled.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W      = 8;
    localparam int CTL_W       = 4;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd2;

    localparam int CB_INMODE = 5;
    localparam int CB_IRQEN  = 4;

    // 1 where register bit and line level are inverted (strobe, autofeed, select)
    localparam logic [CTL_W-1:0] CTL_INV_MASK = 4'b1011;
    // register value that releases every line
    localparam logic [CTL_W-1:0] CTL_RESET    = 4'b0100;
    localparam logic [BYTE_W-1:0] RD_UNMAPPED = 8'hFF;

    typedef enum logic [1:0] {
        ACK_WAIT_LOW = 2'd0,
        ACK_ARMED    = 2'd1,
        ACK_FIRE     = 2'd2
    } ack_state_t;
endpackage

// File: rtl/lpt_reg_bank.sv
module lpt_reg_bank
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] data_latch,
    output logic [CTL_W-1:0]  ctl_bits,
    output logic              in_mode,
    output logic              irq_en
);
    logic wr_data, wr_ctrl;

    always_comb begin
        wr_data = bus_wr && (bus_addr == OFS_DATA);
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_latch <= '0;
        end else if (wr_data) begin
            data_latch <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_bits <= CTL_RESET;
            in_mode  <= 1'b0;
            irq_en   <= 1'b0;
        end else if (wr_ctrl) begin
            ctl_bits <= bus_wdata[CTL_W-1:0];
            in_mode  <= bus_wdata[CB_INMODE];
            irq_en   <= bus_wdata[CB_IRQEN];
        end
    end
endmodule

// File: rtl/lpt_ack_irq.sv
module lpt_ack_irq
    import lpt_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_pin,
    input  logic irq_en,
    output logic irq_out,
    output logic irq_oe
);
    logic [STAGES-1:0] sync_q;
    logic              ack_s;
    ack_state_t        state, state_nx;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= ack_pin;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign ack_s = sync_q[STAGES-1];

    always_comb begin
        state_nx = state;
        unique case (state)
            ACK_WAIT_LOW: if (!ack_s) state_nx = ACK_ARMED;
            ACK_ARMED:    if (ack_s)  state_nx = ACK_FIRE;
            ACK_FIRE:     state_nx = ack_s ? ACK_WAIT_LOW : ACK_ARMED;
            default:      state_nx = ACK_WAIT_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_WAIT_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        irq_oe  = irq_en;
        irq_out = irq_en && (state == ACK_FIRE);
    end
endmodule

// File: rtl/lpt_read_mux.sv
module lpt_read_mux
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] pd_in,
    input  logic [4:0]        status_raw,
    input  logic [CTL_W-1:0]  ctl_pin_in,
    input  logic              in_mode,
    input  logic              irq_en,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [BYTE_W-1:0] stat_byte, ctrl_byte, sel_byte;

    // status_raw order: busy, ack, paper, sel, err
    always_comb begin
        stat_byte = {~status_raw[4], status_raw[3:0], 3'b111};
        ctrl_byte = {2'b11, in_mode, irq_en, ctl_pin_in ^ CTL_INV_MASK};
        unique case (bus_addr)
            OFS_DATA: sel_byte = pd_in;
            OFS_STAT: sel_byte = stat_byte;
            OFS_CTRL: sel_byte = ctrl_byte;
            default:  sel_byte = RD_UNMAPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= sel_byte;
    end
endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [BYTE_W-1:0] pd_in,
    input  logic              st_busy_pin,
    input  logic              st_ack_pin,
    input  logic              st_paper_pin,
    input  logic              st_sel_pin,
    input  logic              st_err_pin,
    output logic [CTL_W-1:0]  ctl_drive_low,
    input  logic [CTL_W-1:0]  ctl_pin_in,
    output logic              irq_out,
    output logic              irq_oe
);
    logic [CTL_W-1:0] ctl_bits;
    logic             in_mode, irq_en;

    lpt_reg_bank u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .data_latch (pd_out),
        .ctl_bits   (ctl_bits),
        .in_mode    (in_mode),
        .irq_en     (irq_en)
    );

    // pull low wherever the intended line level is 0
    assign ctl_drive_low = ~(ctl_bits ^ CTL_INV_MASK);
    assign pd_oe         = ~in_mode;

    lpt_ack_irq #(.STAGES(SYNC_STAGES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_pin (st_ack_pin),
        .irq_en  (irq_en),
        .irq_out (irq_out),
        .irq_oe  (irq_oe)
    );

    lpt_read_mux u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .pd_in      (pd_in),
        .status_raw ({st_busy_pin, st_ack_pin, st_paper_pin, st_sel_pin, st_err_pin}),
        .ctl_pin_in (ctl_pin_in),
        .in_mode    (in_mode),
        .irq_en     (irq_en),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/lpt_host_port_chk.sv
module lpt_host_port_chk
    import lpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [BYTE_W-1:0] pd_out,
    input logic              pd_oe,
    input logic [CTL_W-1:0]  ctl_drive_low,
    input logic              irq_out,
    input logic              irq_oe
);
    assert_data_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |=> pd_out == $past(bus_wdata));

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_DATA) |=> $stable(pd_out));

    assert_input_mode_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> pd_oe == !$past(bus_wdata[CB_INMODE]));

    assert_ctl_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=>
            ctl_drive_low == {$past(bus_wdata[3]), !$past(bus_wdata[2]),
                              $past(bus_wdata[1]), $past(bus_wdata[0])});

    assert_irq_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |=> !irq_out);

    assert_irq_needs_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_oe);

    assert_unmapped_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |=> bus_rdata == RD_UNMAPPED);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind lpt_host_port lpt_host_port_chk u_chk (.*);

// File: tb/test_lpt_host_port.sv
`timescale 1ns/1ps
module test_lpt_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pd_out, pd_in;
    logic       pd_oe;
    logic       st_busy_pin = 1'b0, st_ack_pin = 1'b1, st_paper_pin = 1'b0;
    logic       st_sel_pin = 1'b0, st_err_pin = 1'b1;
    logic [3:0] ctl_drive_low, ctl_pin_in;
    logic       irq_out, irq_oe;

    logic [7:0] ext_data = 8'h00;
    logic [3:0] ext_pull = 4'b0000;

    int checks = 0, fails = 0, irq_count = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    // pin models: data line is ours while driving, otherwise the outside value
    assign pd_in      = pd_oe ? pd_out : ext_data;
    assign ctl_pin_in = ~ctl_drive_low & ~ext_pull;

    lpt_host_port i_lpt_host_port (.*);

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // scoreboard monitor
    always @(negedge clk) begin
        if (irq_out) irq_count++;
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read", bus_rdata, 8'h00);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 8'h00, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(pd_out == 8'h00, "R1 data latch", pd_out, 8'h00);
        chk(pd_oe == 1'b1, "R1 pd_oe", {7'b0, pd_oe}, 8'h01);
        chk(ctl_drive_low == 4'b0000, "R1 lines released", {4'b0, ctl_drive_low}, 8'h00);
        chk(!irq_out && !irq_oe, "R1 irq idle", {6'b0, irq_out, irq_oe}, 8'h00);
        rd(2'd2, 8'hC4, "R1 ctrl reset read");
        rd(2'd0, 8'h00, "R1 data reset read");

        // R2 data out and pin readback
        wr(2'd0, 8'hA5);
        chk(pd_out == 8'hA5, "R2 latch A5", pd_out, 8'hA5);
        rd(2'd0, 8'hA5, "R2 read A5");
        wr(2'd0, 8'h3C);
        rd(2'd0, 8'h3C, "R2 read 3C");

        // R3 input mode
        ext_data = 8'h5A;
        wr(2'd2, 8'h24);
        chk(pd_oe == 1'b0, "R3 pd_oe off", {7'b0, pd_oe}, 8'h00);
        rd(2'd0, 8'h5A, "R3 read pins in input mode");
        wr(2'd0, 8'h81);
        rd(2'd0, 8'h5A, "R3 pins unchanged after write");
        rd(2'd2, 8'hE4, "R3 ctrl shows input bit");
        wr(2'd2, 8'h04);
        chk(pd_oe == 1'b1, "R3 pd_oe back on", {7'b0, pd_oe}, 8'h01);
        rd(2'd0, 8'h81, "R3 stored byte now driven");

        // R4 status polarities
        st_busy_pin = 1; st_ack_pin = 0; st_paper_pin = 1; st_sel_pin = 0; st_err_pin = 1;
        rd(2'd1, 8'h2F, "R4 status pattern A");
        st_busy_pin = 0; st_ack_pin = 1; st_paper_pin = 0; st_sel_pin = 1; st_err_pin = 0;
        rd(2'd1, 8'hD7, "R4 status pattern B");
        st_err_pin = 1; st_sel_pin = 0;

        // R5 control drive polarity
        wr(2'd2, 8'h0B);
        chk(ctl_drive_low == 4'b1111, "R5 0B all low", {4'b0, ctl_drive_low}, 8'h0F);
        rd(2'd2, 8'hCB, "R6 readback all driven");
        wr(2'd2, 8'h01);
        chk(ctl_drive_low == 4'b0101, "R5 01 strobe+init low", {4'b0, ctl_drive_low}, 8'h05);

        // R6 readback of externally pulled lines; R7 top bits
        wr(2'd2, 8'h04);
        ext_pull = 4'b0001;
        rd(2'd2, 8'hC5, "R6 strobe pulled by outside");
        ext_pull = 4'b0100;
        rd(2'd2, 8'hC0, "R6 init pulled by outside");
        ext_pull = 4'b0000;
        wr(2'd2, 8'hC4);
        rd(2'd2, 8'hC4, "R7 top bits still 1");

        // R9 unmapped and ignored writes
        wr(2'd0, 8'h77);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h2B);
        rd(2'd3, 8'hFF, "R9 offset 3 reads FF");
        rd(2'd0, 8'h77, "R9 data untouched");
        rd(2'd2, 8'hC4, "R9 ctrl untouched");
        chk(pd_oe == 1'b1, "R9 pd_oe untouched", {7'b0, pd_oe}, 8'h01);

        // R8 interrupts; ack currently high
        wr(2'd2, 8'h14);
        chk(irq_oe == 1'b1, "R8 irq_oe on", {7'b0, irq_oe}, 8'h01);
        irq_count = 0;
        idle(6);
        chk(irq_count == 0, "R8 no pulse for steady high", irq_count[7:0], 8'h00);
        st_ack_pin = 0; idle(5);
        st_ack_pin = 1; idle(8);
        chk(irq_count == 1, "R8 one pulse per rise", irq_count[7:0], 8'h01);
        idle(10);
        chk(irq_count == 1, "R8 no repeat while held", irq_count[7:0], 8'h01);
        st_ack_pin = 0; idle(5);
        st_ack_pin = 1; idle(8);
        chk(irq_count == 2, "R8 second rise", irq_count[7:0], 8'h02);
        wr(2'd2, 8'h04);
        chk(irq_oe == 1'b0, "R8 irq_oe off", {7'b0, irq_oe}, 8'h00);
        st_ack_pin = 0; idle(5);
        st_ack_pin = 1; idle(8);
        wr(2'd2, 8'h14);
        idle(6);
        chk(irq_count == 2, "R8 edge lost while disabled", irq_count[7:0], 8'h02);

        idle(4);
        chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule